// File: doc/BRIEF.md
# Bit-order selectable 16:1 tree serializer

This block turns a parallel word into a serial bit stream. A new word is accepted once every sixteen cycles of the full-rate clock `clk`, and one bit leaves on `ser_out` in every `clk` cycle after that. An internal rate divider produces the binary-weighted divided clocks C2, C4, C8 and C16. Each of these steers one level of a binary tree of 2:1 multiplexers. The slowest of them, C16, leaves the block as `word_clk` so that the data source can pace itself on it. The word is taken in at the falling edge of `word_clk`.

`bit_order` chooses which end of the word goes out first. A copy of the full-rate clock, `fwd_clk`, travels alongside the data for a receiver that needs a forwarded clock. `clk_off` switches that copy off without glitches. The reset input is asynchronous and active low, and its release is synchronized inside the block.

The number of tree levels is a parameter. The word width is 2 to the power of that count, which gives 16 bits for the default of four levels.

Top module: `ser_tree16`

## Requirements
- R1: `ser_out` is 0 while `rst_n` is low. It stays 0 after release until the first bit of the first captured word is due (see R7).
- R2: `word_clk` is 0 during reset. Once running it has a period of 16 `clk` cycles: 8 cycles low, then 8 cycles high.
- R3: A word is captured only at the `clk` rising edge where `word_clk` falls (divider count 15 wraps to 0). Values on `din` at any other edge have no effect on the stream.
- R4: With `bit_order` = 0 at capture, the word goes out as `din[0]` first, then `din[1]`, and so on up to `din[15]`.
- R5: With `bit_order` = 1 at capture, the word goes out as `din[15]` first, then `din[14]`, and so on down to `din[0]`.
- R6: `bit_order` is sampled only at the capture edge. Changing it while a word is being sent does not alter that word.
- R7: For a word captured at rising edge M, bit position j (0 = first sent) is on `ser_out` for the one cycle following edge M+1+j. Successive words follow each other with no gap.
- R8: While `clk_off` = 0, `fwd_clk` follows `clk`. A change of `clk_off` takes effect at the next falling edge of `clk`.
- R9: While `clk_off` = 1, and while `rst_n` is low, `fwd_clk` is held at 0.
- R10: After `rst_n` rises, the first rising edge of `word_clk` follows the 10th rising edge of `clk`. This is 2 edges of reset synchronization plus 8 edges of counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Parallel word, 2**LEVELS bits |
| bit_order | input | 1 | 0: bit 0 sent first; 1: top bit sent first |
| clk_off | input | 1 | 1 turns the forwarded clock off |
| ser_out | output | 1 | Serial data stream |
| word_clk | output | 1 | Divide-by-16 word-rate clock |
| fwd_clk | output | 1 | Gated copy of `clk` sent with the data |

## Verification
The bench builds the block with the default of four levels. Every one of the 16 leaf positions is therefore selected, and every level of the tree is steered, in both bit orders. Random words change on every cycle, so a capture on the wrong edge or a leaf swapped inside the tree shows up as a wrong bit. Flipping `bit_order` and `clk_off` in the middle of a word exercises the sampling points of R6 and R8. A reset in the middle of the run, followed by single-one words, checks the restart timing of R10 and both ends of the word.

// File: rtl/ser_pkg.sv
package ser_pkg;

  typedef enum logic {
    ORDER_LOW_FIRST  = 1'b0,
    ORDER_HIGH_FIRST = 1'b1
  } order_e;

  // node count of a full binary tree with lv select levels
  function automatic int tree_nodes(input int lv);
    return (2 ** (lv + 1)) - 1;
  endfunction

endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ser_rate_div.sv
module ser_rate_div #(
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [LEVELS-1:0] phase,
  output logic              load_en,
  output logic              word_clk
);

  logic [LEVELS-1:0] cnt_q;
  logic [LEVELS-1:0] cnt_d;

  // bit k of the count is the divide-by-2**(k+1) clock
  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign phase    = cnt_q;
  assign load_en  = &cnt_q;
  assign word_clk = cnt_q[LEVELS-1];

endmodule

// File: rtl/ser_mux_tree.sv
module ser_mux_tree #(
  parameter  int LEVELS = 4,
  localparam int WIDTH  = 1 << LEVELS,
  localparam int NODES  = ser_pkg::tree_nodes(LEVELS)
) (
  input  logic [WIDTH-1:0]  word,
  input  logic [LEVELS-1:0] sel,
  output logic              bit_o
);

  // heap order: node 0 is the root, leaves sit at WIDTH-1 .. NODES-1
  logic [NODES-1:0] node;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_leaf
    assign node[WIDTH-1+gi] = word[gi];
  end

  // depth gd is steered by the divided clock sel[LEVELS-1-gd];
  // the fastest clock picks between neighbouring leaves
  for (genvar gd = 0; gd < LEVELS; gd++) begin : g_depth
    for (genvar gp = 0; gp < (1 << gd); gp++) begin : g_pos
      assign node[(1 << gd) - 1 + gp] = sel[LEVELS-1-gd]
        ? node[(1 << (gd + 1)) - 1 + 2*gp + 1]
        : node[(1 << (gd + 1)) - 1 + 2*gp];
    end
  end

  assign bit_o = node[0];

endmodule

// File: rtl/ser_clk_gate.sv
module ser_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic off,
  output logic gclk
);

  logic en_q;
  logic en_d;

  always_comb begin
    en_d = ~off;
  end

  // enable moves only while clk is low, so the gated copy has no runt pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign gclk = clk & en_q;

endmodule

// File: rtl/ser_tree16.sv
module ser_tree16 #(
  parameter  int LEVELS = 4,
  localparam int WIDTH  = 1 << LEVELS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             bit_order,
  input  logic             clk_off,
  output logic             ser_out,
  output logic             word_clk,
  output logic             fwd_clk
);

  logic              rst_i_n;
  logic [LEVELS-1:0] phase;
  logic              load_en;
  logic [WIDTH-1:0]  din_rev;
  logic [WIDTH-1:0]  word_q, word_d;
  logic              live_q, live_d;
  logic              out_q, out_d;
  logic              tree_bit;

  ser_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ser_rate_div #(.LEVELS(LEVELS)) u_div (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .phase    (phase),
    .load_en  (load_en),
    .word_clk (word_clk)
  );

  assign din_rev = {<<{din}};

  // the order is folded in at capture, so the tree always sends leaf 0 first
  always_comb begin
    word_d = word_q;
    if (load_en) begin
      word_d = (ser_pkg::order_e'(bit_order) == ser_pkg::ORDER_HIGH_FIRST)
             ? din_rev : din;
    end
    live_d = live_q | load_en;
    out_d  = live_q ? tree_bit : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      word_q <= '0;
      live_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      live_q <= live_d;
      out_q  <= out_d;
    end
  end

  ser_mux_tree #(.LEVELS(LEVELS)) u_tree (
    .word  (word_q),
    .sel   (phase),
    .bit_o (tree_bit)
  );

  ser_clk_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .off   (clk_off),
    .gclk  (fwd_clk)
  );

  assign ser_out = out_q;

endmodule

// File: rtl/ser_tree16_chk.sv
module ser_tree16_chk #(
  parameter  int LEVELS = 4,
  localparam int WIDTH  = 1 << LEVELS,
  localparam int HALF   = WIDTH / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] din,
  input logic             bit_order,
  input logic             clk_off,
  input logic             ser_out,
  input logic             word_clk,
  input logic             fwd_clk
);

  logic              wc_d;
  logic              toggled;
  logic              seen_toggle;
  logic              seen_fall;
  logic [LEVELS-1:0] run_len;
  logic              neg_ok;

  assign toggled = (word_clk != wc_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_d        <= 1'b0;
      seen_toggle <= 1'b0;
      seen_fall   <= 1'b0;
      run_len     <= '0;
    end else begin
      wc_d <= word_clk;
      if (toggled) begin
        run_len     <= '0;
        seen_toggle <= 1'b1;
      end else begin
        run_len <= run_len + 1'b1;
      end
      if (wc_d && !word_clk) begin
        seen_fall <= 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_ok <= 1'b0;
    end else begin
      neg_ok <= 1'b1;
    end
  end

  // R1: quiet output before the first word
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fall |-> (ser_out == 1'b0));

  // R2: each word_clk phase lasts half a word
  a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (toggled && seen_toggle) |-> (run_len == LEVELS'(HALF - 1)));

  // R4 and R5: first bit out is the selected end of the captured word
  a_r4_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word_clk) |=>
      (ser_out == ($past(bit_order, 2) ? $past(din[WIDTH-1], 2) : $past(din[0], 2))));

  // R8: forwarded clock present in the high phase when enabled
  a_r8_clk_on: assert property (@(negedge clk) disable iff (!rst_n)
    (neg_ok && !$past(clk_off)) |-> fwd_clk);

  // R9: forwarded clock silent when switched off
  a_r9_clk_off: assert property (@(negedge clk) disable iff (!rst_n)
    (neg_ok && $past(clk_off)) |-> !fwd_clk);

endmodule

bind ser_tree16 ser_tree16_chk #(.LEVELS(LEVELS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .bit_order (bit_order),
  .clk_off   (clk_off),
  .ser_out   (ser_out),
  .word_clk  (word_clk),
  .fwd_clk   (fwd_clk)
);

// File: tb/ser_tree16_tb.sv
`timescale 1ns/1ps
module ser_tree16_tb;

  localparam int LV = 4;
  localparam int W  = 1 << LV;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] din;
  logic         bit_order;
  logic         clk_off;
  logic         ser_out;
  logic         word_clk;
  logic         fwd_clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  ser_tree16 #(.LEVELS(LV)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .bit_order (bit_order),
    .clk_off   (clk_off),
    .ser_out   (ser_out),
    .word_clk  (word_clk),
    .fwd_clk   (fwd_clk)
  );

  // ---------------- reference model ----------------
  int edges;
  bit exp_q;
  bit exp_wc;
  bit en_m;
  int cur_tag;
  bit q_bits[$];
  int q_tags[$];

  always @(posedge clk) begin
    int m;
    if (!rst_n) begin
      edges   = 0;
      exp_q   = 1'b0;
      exp_wc  = 1'b0;
      cur_tag = 1;
      q_bits.delete();
      q_tags.delete();
    end else begin
      edges++;
      m = edges - 2;              // R10: two edges of synchronization
      if (m >= 1) begin
        if (q_bits.size() > 0) begin   // R7: one bit per cycle, back to back
          exp_q   = q_bits.pop_front();
          cur_tag = q_tags.pop_front();
        end else begin
          exp_q   = 1'b0;
          cur_tag = 1;
        end
        if (m % W == 0) begin     // R3: capture where word_clk falls
          for (int j = 0; j < W; j++) begin
            q_bits.push_back(bit_order ? din[W-1-j] : din[j]);
            q_tags.push_back(bit_order ? 5 : 4);
          end
        end
        exp_wc = ((m % W) >= (W / 2));
      end
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_m = 1'b0;
    else        en_m = ~clk_off;
  end

  // ---------------- comparisons ----------------
  always @(posedge clk) begin
    #1;
    total++;
    if (ser_out !== exp_q) begin
      bad++;
      if (cur_tag == 4)
        $display("FAIL R4/R7/R3/R6 ser_out=%b expected %b at %0t", ser_out, exp_q, $time);
      else if (cur_tag == 5)
        $display("FAIL R5/R7/R3/R6 ser_out=%b expected %b at %0t", ser_out, exp_q, $time);
      else
        $display("FAIL R1 ser_out=%b expected %b at %0t", ser_out, exp_q, $time);
    end
    total++;
    if (word_clk !== exp_wc) begin
      bad++;
      $display("FAIL R2/R10 word_clk=%b expected %b at %0t", word_clk, exp_wc, $time);
    end
    total++;
    if (fwd_clk !== en_m) begin
      bad++;
      $display("FAIL R8/R9 fwd_clk high phase=%b expected %b at %0t", fwd_clk, en_m, $time);
    end
  end

  always @(negedge clk) begin
    #1;
    total++;
    if (fwd_clk !== 1'b0) begin
      bad++;
      $display("FAIL R8 fwd_clk low phase=%b expected 0 at %0t", fwd_clk, $time);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input int n, input int mode);
    // mode 0: order 0; 1: order 1; 2: order and clk_off flip randomly (R6, R8, R9)
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      din = W'($urandom);           // changes every cycle, R3
      if (mode == 0) bit_order = 1'b0;
      if (mode == 1) bit_order = 1'b1;
      if (mode == 2) begin
        bit_order = 1'($urandom);
        if ($urandom % 8 == 0) clk_off = ~clk_off;
      end
    end
  endtask

  task automatic hold_word(input logic [W-1:0] w, input logic ord, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      din       = w;
      bit_order = ord;
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    din       = '0;
    bit_order = 1'b0;
    clk_off   = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;                // R1, R10 from here
    drive(8 * W, 0);                // R4
    clk_off = 1'b1;                 // R9
    drive(8 * W, 1);                // R5
    clk_off = 1'b0;
    drive(16 * W, 2);               // R6, R8
    @(negedge clk); #1 rst_n = 1'b0; // reset mid-stream, R1
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;                // R10 again
    clk_off = 1'b0;
    hold_word(16'h0001, 1'b0, 2 * W);  // boundary words, R4
    hold_word(16'h0001, 1'b1, 2 * W);  // R5
    hold_word(16'h8000, 1'b0, 2 * W);
    hold_word(16'h8000, 1'b1, 2 * W);
    drive(4 * W, 2);
    repeat (3 * W) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish, got running expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule